// File: doc/BRIEF.md
# Two-Digit BCD Doubler

This block takes a packed decimal value of two BCD digits and returns twice that value, also in packed BCD, together with a hundreds digit that is either 0 or 1. A chain of identical per-digit slices does the work, starting at the least significant digit. Each slice looks at its own digit and at the carry from the slice below it. It gives back one corrected result digit and a carry for the slice above.

Each slice does not compare the doubled sum against ten afterwards. It tests its input digit first. A digit above four gets a bias of three and then moves left one place. The carry from below fills the freed bit. A digit of four or less just moves left. The bias turns the binary patterns for 10 to 19 into correct BCD, and the bit that drops off the top becomes the carry-out.

An enable input chooses between two ways of delivering the result. With the enable low, the result passes straight through with no clock involved. With it high, an output register captures the result on each rising clock edge, which adds one cycle of latency. The block has no state machine. The register is the only sequential element and it has a single operating mode.

Top module: `bcd_doubler`

## Requirements
- R1: A digit slice whose input digit is 0 to 4 produces twice the digit plus its carry-in as its result digit, and a carry-out of 0.
- R2: A digit slice whose input digit is 5 to 9 produces (2 × (digit + 3) + carry-in) mod 16 as its result digit, and a carry-out of 1.
- R3: The lowest slice has a carry-in of 0. Each slice's carry-out enters bit 0 of the result digit of the slice above it.
- R4: For every legal input 00 to 99, with digits_in[3:0] as the units digit and digits_in[7:4] as the tens digit, the outputs equal twice the input in decimal. digits_out[3:0] is the units digit, digits_out[7:4] is the tens digit, and every output digit is 9 or less.
- R5: hundreds_out is the carry-out of the top slice. It is 1 exactly when the input is 50 or more, so inputs 50 to 99 give 100 to 198.
- R6: With reg_en = 0, the outputs follow digits_in within the same cycle, without waiting for a clock edge.
- R7: With reg_en = 1, the outputs show the doubled value of the input sampled at the previous rising clock edge, and they hold steady between edges while the input changes.
- R8: While rst_n is low, the output register holds zero. With reg_en = 1, the outputs then read 000.
- R9: Input 21 gives 042, input 42 gives 084 and input 27 gives 054.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low, clears the output register |
| reg_en | input | 1 | 1 = outputs come from the register (one-cycle latency), 0 = outputs pass straight through |
| digits_in | input | 4*NDIGITS (8) | Packed BCD input, units digit in the low nibble |
| digits_out | output | 4*NDIGITS (8) | Packed BCD doubled value, units digit in the low nibble |
| hundreds_out | output | 1 | Carry from the top slice, used as the hundreds digit |

## Verification
The bench sweeps all hundred legal inputs twice: once straight through and once through the register. It compares each result with a decimal product computed in the bench. Units digits of 5 to 9 exercise the bias path and the carry into the tens digit. Units digits of 0 to 4 exercise the plain shift. Tens digits on either side of five separate the cases with hundreds_out at 0 from those with hundreds_out at 1. Separate probes change the input between clock edges in each mode. They show whether the output follows the input at once or waits for the next edge.

// File: rtl/bcd_dbl_pkg.sv
package bcd_dbl_pkg;
    localparam int DIGIT_W = 4;
    localparam int MAX_DIGIT = 9;
    localparam int BIAS = 3;
    localparam int HALF_RADIX = 5;

    typedef logic [DIGIT_W-1:0] digit_t;

    function automatic logic is_legal(input digit_t d);
        return (d <= digit_t'(MAX_DIGIT));
    endfunction
endpackage

// File: rtl/bcd_dbl_slice.sv
module bcd_dbl_slice
    import bcd_dbl_pkg::*;
(
    input  digit_t digit_i,
    input  logic   carry_i,
    output digit_t digit_o,
    output logic   carry_o
);
    logic   over_half;
    digit_t biased;

    always_comb begin
        over_half = (digit_i >= digit_t'(HALF_RADIX));
        biased    = digit_i + (over_half ? digit_t'(BIAS) : digit_t'(0));
        digit_o   = {biased[DIGIT_W-2:0], carry_i};
        carry_o   = biased[DIGIT_W-1];
    end

    always_comb begin
        if (!$isunknown({digit_i, carry_i}) && is_legal(digit_i)) begin
            if (digit_i < digit_t'(HALF_RADIX)) begin
                a_r1_small_no_carry: assert (carry_o == 1'b0 && digit_o[0] == carry_i)
                    else $error("R1 slice carry or lsb wrong");
            end else begin
                a_r2_large_carry: assert (carry_o == 1'b1)
                    else $error("R2 slice carry missing");
            end
            a_r4_digit_legal: assert (digit_o <= digit_t'(MAX_DIGIT))
                else $error("R4 slice result not BCD");
        end
    end
endmodule

// File: rtl/bcd_dbl_chain.sv
module bcd_dbl_chain
    import bcd_dbl_pkg::*;
#(
    parameter int NDIGITS = 2
) (
    input  logic [DIGIT_W*NDIGITS-1:0] digits_i,
    output logic [DIGIT_W*NDIGITS-1:0] digits_o,
    output logic                       carry_o
);
    logic [NDIGITS:0] carry;

    assign carry[0] = 1'b0;

    for (genvar g = 0; g < NDIGITS; g++) begin : g_slice
        bcd_dbl_slice u_slice (
            .digit_i (digits_i[g*DIGIT_W +: DIGIT_W]),
            .carry_i (carry[g]),
            .digit_o (digits_o[g*DIGIT_W +: DIGIT_W]),
            .carry_o (carry[g+1])
        );

        if (g > 0) begin : g_link
            always_comb begin
                if (!$isunknown(digits_i[(g-1)*DIGIT_W +: DIGIT_W])) begin
                    a_r3_carry_lands: assert (digits_o[g*DIGIT_W] ==
                        (digits_i[(g-1)*DIGIT_W +: DIGIT_W] >= digit_t'(HALF_RADIX)))
                        else $error("R3 carry not in upper lsb");
                end
            end
        end
    end

    assign carry_o = carry[NDIGITS];

    always_comb begin
        if (!$isunknown(digits_i[DIGIT_W*NDIGITS-1 -: DIGIT_W])) begin
            a_r5_hundreds: assert (carry_o ==
                (digits_i[DIGIT_W*NDIGITS-1 -: DIGIT_W] >= digit_t'(HALF_RADIX)))
                else $error("R5 hundreds carry wrong");
        end
    end
endmodule

// File: rtl/bcd_dbl_outreg.sv
module bcd_dbl_outreg #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    a_r8_reset_clear: assert property (@(posedge clk) !rst_n |-> q == '0)
        else $error("R8 register not clear in reset");
endmodule

// File: rtl/bcd_doubler.sv
module bcd_doubler
    import bcd_dbl_pkg::*;
#(
    parameter int NDIGITS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_en,
    input  logic [DIGIT_W*NDIGITS-1:0] digits_in,
    output logic [DIGIT_W*NDIGITS-1:0] digits_out,
    output logic                       hundreds_out
);
    localparam int DW = DIGIT_W * NDIGITS;
    localparam int RW = DW + 1;

    logic [DW-1:0] comb_digits;
    logic          comb_carry;
    logic [RW-1:0] held;

    bcd_dbl_chain #(.NDIGITS(NDIGITS)) u_chain (
        .digits_i (digits_in),
        .digits_o (comb_digits),
        .carry_o  (comb_carry)
    );

    bcd_dbl_outreg #(.WIDTH(RW)) u_outreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reg_en),
        .d     ({comb_carry, comb_digits}),
        .q     (held)
    );

    always_comb begin
        if (reg_en) begin
            {hundreds_out, digits_out} = held;
        end else begin
            {hundreds_out, digits_out} = {comb_carry, comb_digits};
        end
    end

    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && $past(reg_en) && $past(rst_n)) |->
            {hundreds_out, digits_out} == $past({comb_carry, comb_digits}))
        else $error("R7 registered output not one cycle late");
endmodule

// File: tb/bcd_doubler_tb.sv
module bcd_doubler_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_en;
    logic [7:0] digits_in;
    logic [7:0] digits_out;
    logic       hundreds_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    bcd_doubler u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_en       (reg_en),
        .digits_in    (digits_in),
        .digits_out   (digits_out),
        .hundreds_out (hundreds_out)
    );

    function automatic logic [8:0] ref_double(input int v);
        int p;
        p = 2 * v;
        return {1'(p / 100), 4'((p / 10) % 10), 4'(p % 10)};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input int v, input logic mode, input string req);
        @(negedge clk);
        reg_en    = mode;
        digits_in = {4'(v / 10), 4'(v % 10)};
        exp_q.push_back(ref_double(v));
        tag_q.push_back(req);
    endtask

    // monitor: samples 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " digits"}, {1'b0, digits_out}, {1'b0, e[7:0]});
            check("R5 hundreds", {8'd0, hundreds_out}, {8'd0, e[8]});
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        reg_en    = 1'b1;
        digits_in = 8'h99;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset", {hundreds_out, digits_out}, 9'h000);
        rst_n = 1'b1;

        // R9 named examples, straight through
        drive(21, 1'b0, "R9");
        drive(42, 1'b0, "R9");
        drive(27, 1'b0, "R9");

        // R4 full sweep straight through; R1 low units, R2/R3 high units
        for (int v = 0; v < 100; v++) begin
            drive(v, 1'b0, ((v % 10) >= 5) ? "R4 R2 R3" : "R4 R1");
        end

        // R7 full sweep through the register
        for (int v = 0; v < 100; v++) begin
            drive(v, 1'b1, "R7 R4");
        end
        @(posedge clk);
        wait (exp_q.size() == 0);
        #20;

        // R6: no clock edge needed in pass-through mode
        @(negedge clk);
        reg_en    = 1'b0;
        digits_in = 8'h37;
        #2;
        check("R6 immediate", {hundreds_out, digits_out}, 9'h074);
        digits_in = 8'h68;
        #2;
        check("R6 immediate", {hundreds_out, digits_out}, 9'h136);

        // R7: output holds between edges, updates after the edge
        @(negedge clk);
        reg_en    = 1'b1;
        digits_in = 8'h45;
        @(posedge clk);
        #3;
        check("R7 captured", {hundreds_out, digits_out}, 9'h090);
        digits_in = 8'h99;
        #3;
        check("R7 hold", {hundreds_out, digits_out}, 9'h090);
        @(posedge clk);
        #3;
        check("R7 next edge", {hundreds_out, digits_out}, 9'h198);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule